// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block sits between a set of peripheral interrupt lines and a processor core. It accepts up to 60 request lines. Each line has an enable bit, a pending latch and a 4-bit urgency value. The block always offers the core the most urgent line that is allowed to run. Software programs the block through a simple single-cycle write port. Through that port it sets or clears line enables, writes per-line urgency bytes, and chooses how each urgency value splits into a preemption part and a sub-priority part.

The block drives a request flag and the number of the line that wins. The core accepts that line with an acknowledge and later reports the end of its handler. The block keeps a stack of the handlers that are currently nested. A new request is offered only when its preemption part beats the handler on top of that stack. The sub-priority part only decides the order among requests that are waiting.

Register map of the write port (7-bit address, 32-bit data):
- Address 0 and 1 set enables. Address 2 and 3 clear enables.
- Address 4 holds the grouping field in data bits 2:0.
- Address 64+k holds the urgency byte of line k.

Top module: `prio_nest_arb`

## Requirements
- R1: After reset every line is disabled, every urgency value is 0, the grouping field is 0, no line is pending and the handler stack is empty, so `req_valid_o` is low.
- R2: A low-to-high transition on `irq_i[k]`, seen at a clock edge, sets the pending latch of line k. A line held high does not set its latch again after an acknowledge until it has gone low and risen again.
- R3: A write to address 0 or 1 sets the enable of line 32*addr+b for every data bit b that is 1. A write to address 2 or 3 clears the enable of line 32*(addr-2)+b for every data bit b that is 1. Data bits that are 0 leave their enables unchanged.
- R4: A pending line that is disabled keeps its pending latch but is never offered. It is offered once it is enabled again.
- R5: A write to address 64+k (k below 60) loads data bits 7:4 as the urgency value of line k. Data bits 3:0 are ignored.
- R6: Among lines that are both pending and enabled, the winner has the numerically smallest urgency value. When urgency values are equal, the lowest line number wins. Because the preemption bits are the upper bits, this order compares the preemption part first and the sub-priority part second.
- R7: The grouping field n (0 to 4) makes the top n urgency bits the preemption part; the remaining bits are the sub-priority part. Field values 5 to 7 behave as 4.
- R8: The winner is offered (`req_valid_o` high, `req_id_o` = its number) if the stack is empty. Otherwise it is offered only if its preemption part, left-aligned in 4 bits with the sub-priority bits zeroed, is strictly smaller than the value on top of the stack.
- R9: `ack_i` while a request is offered clears the pending latch of the offered line and pushes its left-aligned preemption part onto the stack. `ack_i` with no request offered has no effect.
- R10: `eoh_i` pops the stack. It is ignored when the stack is empty and in a cycle where an acknowledge is taken.
- R11: A pushed stack value keeps the grouping in force at its acknowledge. A later change of the grouping field affects only new decisions.
- R12: The stack never holds more than 16 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 60 | Interrupt request lines, edge sensitive |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration write address |
| cfg_wdata_i | input | 32 | Configuration write data |
| ack_i | input | 1 | Core accepts the offered line |
| eoh_i | input | 1 | Core has finished its innermost handler |
| req_valid_o | output | 1 | A line is offered to the core |
| req_id_o | output | 6 | Number of the offered line, meaningful when `req_valid_o` is high |

## Verification
The outputs depend only on registered state. A request edge, a configuration write, an acknowledge or an end-of-handler sampled at rising edge N therefore shows on `req_valid_o`/`req_id_o` right after edge N, with no further delay. The bench drives inputs on falling edges and reads the outputs on the next falling edge, which is half a cycle after the edge that took the stimulus. A behavioural model in the bench receives the same inputs at each rising edge and is compared against the outputs on every falling edge. The directed checks then name the expected winner at the stack depths and grouping values where the strict-preemption and tie-breaking rules matter.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
    // Base address of the per-line urgency bytes
    localparam int PRIO_BASE = 64;
    localparam int WORD_BITS = 32;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SET,
        ACC_CLR,
        ACC_GRP,
        ACC_PRIO
    } acc_kind_e;

    // Grouping values above the urgency width behave as the full width
    function automatic int clamp_group(input int g, input int pw);
        return (g > pw) ? pw : g;
    endfunction
endpackage

// File: rtl/arb_cfg_regs.sv
`timescale 1ns/1ps
module arb_cfg_regs
    import arb_pkg::*;
#(
    parameter int N      = 60,
    parameter int PW     = 4,
    parameter int GW     = 3,
    parameter int DW     = 32,
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]   wr_data_i,
    output logic [N-1:0]    en_o,
    output logic [N*PW-1:0] prio_o,
    output logic [GW-1:0]   grp_o
);
    localparam int WORDS = (N + WORD_BITS - 1) / WORD_BITS;

    typedef struct packed {
        logic [N-1:0]    en;
        logic [N*PW-1:0] prio;
        logic [GW-1:0]   grp;
    } cfg_t;

    cfg_t      st_d, st_q;
    acc_kind_e kind;
    int        a;

    always_comb begin
        a    = int'(wr_addr_i);
        kind = ACC_NONE;
        if (wr_en_i) begin
            if (a < WORDS)                                kind = ACC_SET;
            else if (a < 2 * WORDS)                       kind = ACC_CLR;
            else if (a == 2 * WORDS)                      kind = ACC_GRP;
            else if (a >= PRIO_BASE && a < PRIO_BASE + N) kind = ACC_PRIO;
        end

        st_d = st_q;
        case (kind)
            ACC_SET: begin
                for (int i = 0; i < N; i++) begin
                    if ((i / WORD_BITS) == a && wr_data_i[i % WORD_BITS]) st_d.en[i] = 1'b1;
                end
            end
            ACC_CLR: begin
                for (int i = 0; i < N; i++) begin
                    if ((i / WORD_BITS) == a - WORDS && wr_data_i[i % WORD_BITS]) st_d.en[i] = 1'b0;
                end
            end
            ACC_GRP:  st_d.grp = wr_data_i[GW-1:0];
            ACC_PRIO: st_d.prio[(a - PRIO_BASE) * PW +: PW] = wr_data_i[7 -: PW];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign prio_o = st_q.prio;
    assign grp_o  = st_q.grp;
endmodule

// File: rtl/arb_select.sv
`timescale 1ns/1ps
module arb_select #(
    parameter int N   = 60,
    parameter int PW  = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]    cand_i,
    input  logic [N*PW-1:0] prio_i,
    output logic            win_v_o,
    output logic [IDW-1:0]  win_id_o,
    output logic [PW-1:0]   win_p_o
);
    localparam int LG     = IDW;
    localparam int LEAVES = 1 << LG;

    logic [LEAVES-1:0] v;
    logic [PW-1:0]     p  [LEAVES];
    logic [IDW-1:0]    id [LEAVES];
    logic              pick_l;

    // Balanced compare tree; the left operand always holds the lower line numbers
    always_comb begin
        pick_l = 1'b0;
        for (int i = 0; i < LEAVES; i++) begin
            v[i]  = (i < N) && cand_i[i % N];
            p[i]  = prio_i[(i % N) * PW +: PW];
            id[i] = IDW'(i);
        end
        for (int lv = LG - 1; lv >= 0; lv--) begin
            for (int n = 0; n < (1 << lv); n++) begin
                pick_l = v[2*n] && (!v[2*n+1] || p[2*n] <= p[2*n+1]);
                v[n]   = v[2*n] | v[2*n+1];
                p[n]   = pick_l ? p[2*n]  : p[2*n+1];
                id[n]  = pick_l ? id[2*n] : id[2*n+1];
            end
        end
        win_v_o  = v[0];
        win_p_o  = p[0];
        win_id_o = id[0];
    end
endmodule

// File: rtl/arb_stack.sv
`timescale 1ns/1ps
module arb_stack #(
    parameter int PW    = 4,
    parameter int DEPTH = 1 << PW,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [PW-1:0] push_val_i,
    input  logic          pop_i,
    output logic [CW-1:0] cnt_o,
    output logic [PW-1:0] top_o,
    output logic          empty_o
);
    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] ent;
        logic [CW-1:0]            cnt;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i && int'(st_q.cnt) < DEPTH) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (e == int'(st_q.cnt)) st_d.ent[e] = push_val_i;
            end
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (pop_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_comb begin
        top_o = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (e + 1 == int'(st_q.cnt)) top_o = st_q.ent[e];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign empty_o = (st_q.cnt == '0);
endmodule

// File: rtl/prio_nest_arb.sv
`timescale 1ns/1ps
module prio_nest_arb
    import arb_pkg::*;
#(
    parameter  int N      = 60,
    parameter  int PW     = 4,
    parameter  int GW     = 3,
    parameter  int DW     = 32,
    parameter  int ADDR_W = 7,
    localparam int IDW    = $clog2(N),
    localparam int DEPTH  = 1 << PW,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DW-1:0]     cfg_wdata_i,
    input  logic              ack_i,
    input  logic              eoh_i,
    output logic              req_valid_o,
    output logic [IDW-1:0]    req_id_o
);
    typedef struct packed {
        logic [N-1:0] irq;
        logic [N-1:0] pend;
    } line_t;

    line_t st_d, st_q;

    logic [N-1:0]    en_w;
    logic [N*PW-1:0] prio_w;
    logic [GW-1:0]   grp_w;
    logic            sel_v;
    logic [IDW-1:0]  sel_id;
    logic [PW-1:0]   sel_p;
    logic [CW-1:0]   stk_cnt;
    logic [PW-1:0]   stk_top;
    logic            stk_empty;
    logic [N-1:0]    cand;
    logic [PW-1:0]   pre_mask;
    logic [PW-1:0]   cand_pre;
    logic            take;
    logic            pop;
    logic [N-1:0]    clr;
    int              grp_c;

    arb_cfg_regs #(.N(N), .PW(PW), .GW(GW), .DW(DW), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_we_i),
        .wr_addr_i (cfg_addr_i),
        .wr_data_i (cfg_wdata_i),
        .en_o      (en_w),
        .prio_o    (prio_w),
        .grp_o     (grp_w)
    );

    arb_select #(.N(N), .PW(PW), .IDW(IDW)) u_sel (
        .cand_i   (cand),
        .prio_i   (prio_w),
        .win_v_o  (sel_v),
        .win_id_o (sel_id),
        .win_p_o  (sel_p)
    );

    arb_stack #(.PW(PW), .DEPTH(DEPTH), .CW(CW)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .push_val_i (cand_pre),
        .pop_i      (pop),
        .cnt_o      (stk_cnt),
        .top_o      (stk_top),
        .empty_o    (stk_empty)
    );

    always_comb begin
        grp_c = clamp_group(int'(grp_w), PW);
        for (int b = 0; b < PW; b++) pre_mask[PW-1-b] = (b < grp_c);

        cand        = st_q.pend & en_w;
        cand_pre    = sel_p & pre_mask;
        req_valid_o = sel_v && (stk_empty || cand_pre < stk_top);
        req_id_o    = sel_id;
        take        = ack_i && req_valid_o;
        pop         = eoh_i && !take;

        for (int i = 0; i < N; i++) clr[i] = take && (sel_id == IDW'(i));

        st_d.irq  = irq_i;
        st_d.pend = (st_q.pend & ~clr) | (irq_i & ~st_q.irq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/prio_nest_arb_chk.sv
`timescale 1ns/1ps
module prio_nest_arb_chk #(
    parameter int N   = 60,
    parameter int PW  = 4,
    parameter int IDW = 6,
    parameter int CW  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ack_i,
    input logic           eoh_i,
    input logic           req_valid_o,
    input logic [IDW-1:0] req_id_o,
    input logic [N-1:0]   cand,
    input logic [CW-1:0]  depth,
    input logic [PW-1:0]  top,
    input logic [PW-1:0]  cand_pre,
    input logic           empty
);
    localparam int DEPTH = 1 << PW;

    // R12
    stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= DEPTH);

    // R4
    offer_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> cand[req_id_o]);

    // R8
    offer_beats_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !empty) |-> (cand_pre < top));

    // R9
    push_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_valid_o) |=> (depth == $past(depth) + CW'(1)));

    // R10
    pop_on_eoh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoh_i && !(ack_i && req_valid_o) && !empty) |=> (depth == $past(depth) - CW'(1)));

    // R10
    depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack_i && req_valid_o) && !(eoh_i && !empty)) |=> $stable(depth));
endmodule

bind prio_nest_arb prio_nest_arb_chk #(.N(N), .PW(PW), .IDW(IDW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .eoh_i       (eoh_i),
    .req_valid_o (req_valid_o),
    .req_id_o    (req_id_o),
    .cand        (cand),
    .depth       (stk_cnt),
    .top         (stk_top),
    .cand_pre    (cand_pre),
    .empty       (stk_empty)
);

// File: tb/sim_prio_nest_arb.sv
`timescale 1ns/1ps
module sim_prio_nest_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [59:0] irq = '0;
    logic        we = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack = 1'b0;
    logic        eoh = 1'b0;
    logic        req_valid;
    logic [5:0]  req_id;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    prio_nest_arb u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .ack_i       (ack),
        .eoh_i       (eoh),
        .req_valid_o (req_valid),
        .req_id_o    (req_id)
    );

    // Behavioural reference model
    int m_en[60];
    int m_prio[60];
    int m_pend[60];
    int m_prev[60];
    int m_grp;
    int stk[$];

    function automatic int grp_mask(input int g);
        int gc;
        gc = (g > 4) ? 4 : g;
        return (gc == 0) ? 0 : ((15 << (4 - gc)) & 15);
    endfunction

    function automatic void m_decide(output int v, output int id, output int pre);
        int best;
        best = -1;
        for (int k = 0; k < 60; k++) begin
            if (m_pend[k] != 0 && m_en[k] != 0) begin
                if (best < 0 || m_prio[k] < m_prio[best]) best = k;
            end
        end
        id  = best;
        pre = (best >= 0) ? (m_prio[best] & grp_mask(m_grp)) : 0;
        v   = (best >= 0 && (stk.size() == 0 || pre < stk[stk.size()-1])) ? 1 : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 60; k++) begin
                m_en[k] = 0; m_prio[k] = 0; m_pend[k] = 0; m_prev[k] = 0;
            end
            m_grp = 0;
            stk.delete();
        end else begin
            int dv, did, dpre, a;
            bit tk;
            m_decide(dv, did, dpre);
            tk = ack && (dv != 0);
            if (we) begin
                a = int'(addr);
                if (a < 2) begin
                    for (int k = 0; k < 60; k++) if (k / 32 == a && wdata[k % 32]) m_en[k] = 1;
                end else if (a < 4) begin
                    for (int k = 0; k < 60; k++) if (k / 32 == a - 2 && wdata[k % 32]) m_en[k] = 0;
                end else if (a == 4) begin
                    m_grp = int'(wdata[2:0]);
                end else if (a >= 64 && a < 124) begin
                    m_prio[a - 64] = int'(wdata[7:4]);
                end
            end
            for (int k = 0; k < 60; k++) begin
                if (tk && k == did) m_pend[k] = 0;
                if (irq[k] && m_prev[k] == 0) m_pend[k] = 1;
                m_prev[k] = irq[k] ? 1 : 0;
            end
            if (tk) stk.push_back(dpre);
            else if (eoh && stk.size() > 0) void'(stk.pop_back());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R6 R8: model comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            int v, id, pre;
            m_decide(v, id, pre);
            chk("R6/R8 model valid", int'(req_valid), v);
            if (v != 0 && req_valid) chk("R6/R8 model id", int'(req_id), id);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        we = 1'b1; addr = 7'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic raise(input int k);
        irq[k] = 1'b1;
        @(negedge clk);
    endtask

    task automatic drop_all();
        irq = '0;
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eoh();
        eoh = 1'b1; @(negedge clk); eoh = 1'b0;
    endtask

    task automatic expect_req(input string tag, input int v, input int id);
        chk(tag, int'(req_valid), v);
        if (v != 0) chk(tag, int'(req_id), id);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_req("R1 reset idle", 0, 0);

        // R4 / R3 / R2
        raise(5);
        expect_req("R4 disabled pending hidden", 0, 0);
        wr(0, 32'h20);
        expect_req("R3 set enable offers 5", 1, 5);
        do_ack();
        expect_req("R9 ack clears pending", 0, 0);
        do_eoh();
        expect_req("R2 held level no re-pend", 0, 0);
        drop_all();

        // Grouping 2: R6 R8
        wr(4, 32'd2);
        wr(64 + 3,  32'hB0);
        wr(64 + 20, 32'h90);
        wr(64 + 40, 32'h90);
        wr(64 + 50, 32'h40);
        wr(0, (32'd1 << 3) | (32'd1 << 20));
        wr(1, (32'd1 << 8) | (32'd1 << 18));
        irq[3] = 1'b1; irq[20] = 1'b1; irq[40] = 1'b1;
        tick(1);
        expect_req("R6 sub-priority then lower id", 1, 20);
        do_ack();
        expect_req("R8 equal preemption blocked", 0, 0);
        raise(50);
        expect_req("R8 better preemption offered", 1, 50);
        do_ack();
        expect_req("R8 nested top blocks", 0, 0);
        do_eoh();
        expect_req("R10 pop restores threshold", 0, 0);
        do_eoh();
        expect_req("R6 next best after empty", 1, 40);
        do_ack(); do_eoh();
        expect_req("R6 last remaining", 1, 3);
        do_ack(); do_eoh();
        expect_req("R9 all served", 0, 0);
        drop_all();

        // R3 clear enable
        raise(20);
        expect_req("R3 pending 20", 1, 20);
        wr(2, 32'd1 << 20);
        expect_req("R3 clear enable hides 20", 0, 0);
        wr(0, 32'd0);
        expect_req("R3 zero bits no effect", 0, 0);
        wr(0, 32'd1 << 20);
        expect_req("R4 re-enable offers kept pending", 1, 20);
        do_ack(); do_eoh();
        drop_all();

        // R7 group 0, R11 regroup while active
        wr(4, 32'd0);
        raise(3);
        expect_req("R7 group0 offer", 1, 3);
        do_ack();
        raise(50);
        expect_req("R7 group0 no preemption", 0, 0);
        wr(4, 32'd4);
        expect_req("R11 stacked value kept", 0, 0);
        do_eoh();
        expect_req("R11 after pop", 1, 50);
        do_ack(); do_eoh();
        drop_all();

        // R7 field 7 acts as 4
        wr(4, 32'd7);
        wr(64 + 50, 32'h80);
        raise(20);
        expect_req("R7 offer 20", 1, 20);
        do_ack();
        raise(50);
        expect_req("R7 group7 as 4 preempts", 1, 50);
        do_ack(); do_eoh(); do_eoh();
        drop_all();
        expect_req("R10 drained", 0, 0);

        // R5 lower nibble ignored
        wr(64 + 1, 32'h2F);
        wr(64 + 0, 32'h30);
        wr(0, 32'h3);
        irq[0] = 1'b1; irq[1] = 1'b1;
        tick(1);
        expect_req("R5 upper nibble only", 1, 1);
        do_ack(); do_eoh();
        expect_req("R5 next", 1, 0);
        do_ack(); do_eoh();
        drop_all();

        // R10 ack with eoh, eoh on empty; R9 ack without request
        raise(50);
        expect_req("R10 offer 50", 1, 50);
        ack = 1'b1; eoh = 1'b1; tick(1); ack = 1'b0; eoh = 1'b0;
        raise(20);
        expect_req("R10 eoh ignored with ack", 0, 0);
        do_eoh();
        expect_req("R10 pop then offer 20", 1, 20);
        do_ack(); do_eoh();
        drop_all();
        do_eoh(); do_eoh();
        do_ack();
        raise(50);
        expect_req("R9 idle ack ignored", 1, 50);
        do_ack(); do_eoh();
        drop_all();

        // R12 full nesting of 16 levels
        for (int i = 0; i < 16; i++) wr(64 + i, 32'((15 - i) << 4));
        wr(0, 32'h0000FFFF);
        for (int i = 0; i < 16; i++) begin
            raise(i);
            expect_req("R12 nest level offer", 1, i);
            do_ack();
        end
        raise(20);
        expect_req("R12 full stack blocks", 0, 0);
        for (int i = 0; i < 9; i++) do_eoh();
        expect_req("R8 equal top after 9 pops", 0, 0);
        do_eoh();
        expect_req("R8 offer after 10 pops", 1, 20);
        for (int i = 0; i < 6; i++) do_eoh();
        expect_req("R12 drained offers 20", 1, 20);
        drop_all();

        tick(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule